// File: doc/BRIEF.md
# Interrupt-Capable Eight-Pin GPIO Port

This block is one general-purpose I/O port of a small microcontroller. Software reaches it through a register bus with one access per clock: a write strobe with an address and a byte, and a combinational read path. Every pin has one bit in the latch register, one in the direction register and one in the interrupt-enable register, at the bit position that matches the pin number. A pin can be a plain input, an input that raises interrupts, or a push-pull output driven from its latch bit.

Input pins pass through a two-flop synchronizer. The synchronized level feeds the data read path and an edge detector. A two-bit sensitivity field for each pin sets which events count. Edge events latch into a per-pin pending flag, which software clears by writing 1 to that flag. A single interrupt request combines all pending flags with any active low-level condition.

The pad side is modelled as two buses. The output-enable bus is the direction register and the output-data bus is the latch. This lets software preload a level before it turns a pin into an output.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset the latch, direction, enable, sensitivity and pending registers all read 0, `pad_oe` is 0 and `irq` is 0.
- R2: `pad_oe` equals the direction register (1 = output) and `pad_out` equals the data latch at all times.
- R3: Reading address 0 returns the latch bit for output pins and the synchronized pin level for input pins; an input change is visible after the second rising clock edge that follows it.
- R4: A write to address 0 always updates the latch and `pad_out`, whatever the direction bits are. It leaves `pad_oe` alone, and reads of input bits still show the pin level.
- R5: When a direction bit goes from 0 to 1, `pad_out` for that pin already holds the preloaded latch value in the first cycle that `pad_oe` is 1.
- R6: Register map: 0 data, 1 direction, 2 interrupt enable, 3 sensitivity of pins 0–3, 4 sensitivity of pins 4–7 (pin p at bits 2(p mod 4)+1:2(p mod 4)), 5 pending. Direction, enable and sensitivity read back as written, and reads of addresses 6 and 7 return 0.
- R7: A pin raises neither a pending flag nor a level request unless its direction bit is 0 and its enable bit is 1.
- R8: With sensitivity 01, a rising synchronized edge on an enabled pin sets its pending bit after the third rising clock edge following the pin change. A falling edge does nothing.
- R9: With sensitivity 10, only falling edges set the pending bit, with the same timing.
- R10: With sensitivity 11, both rising and falling edges set the pending bit.
- R11: With sensitivity 00, falling edges set the pending bit. In addition, `irq` is high whenever the enabled pin's synchronized level is low, from the second edge after the pin goes low, and this holds even after the pending bit is cleared.
- R12: Writing 1 to a bit of address 5 clears that pending bit, and writing 0 leaves it. An edge event in the same cycle as the clear wins. `irq` is the OR of all pending bits and all level requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not selected |
| pin_in | input | 8 | Asynchronous pin levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output level |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes take effect at the edge that ends the write cycle. Direction, latch and pad values are therefore checked one time step after that edge. A pin change is applied at a falling edge. Its read value is checked at the falling edge after the second following rising edge, and a level request on `irq` is due at that same point. The pending bit and its `irq` contribution are checked only after the third rising edge. The bench counts edges explicitly before each sample, so every check lands in the first cycle its result is due. The sweep covers every pin in every sensitivity mode, with all other pins toggled along but not enabled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // sensitivity codes per pin
  typedef enum logic [1:0] {
    SENS_FALL_LOW = 2'b00,
    SENS_RISE     = 2'b01,
    SENS_FALL     = 2'b10,
    SENS_BOTH     = 2'b11
  } sens_e;

  // register addresses
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_DIR  = 3'd1;
  localparam logic [2:0] A_IEN  = 3'd2;
  localparam logic [2:0] A_SLO  = 3'd3;
  localparam logic [2:0] A_SHI  = 3'd4;
  localparam logic [2:0] A_PEND = 3'd5;

  // edge qualification for one pin
  function automatic logic edge_hit(sens_e s, logic prev, logic cur);
    logic rise, fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    case (s)
      SENS_RISE:     edge_hit = rise;
      SENS_FALL:     edge_hit = fall;
      SENS_BOTH:     edge_hit = rise | fall;
      default:       edge_hit = fall;
    endcase
  endfunction

  // level request for one pin
  function automatic logic level_hit(sens_e s, logic cur);
    level_hit = (s == SENS_FALL_LOW) && !cur;
  endfunction

  // read mux for the data address: latch on outputs, pin on inputs
  function automatic logic [7:0] data_view(logic [7:0] dir, logic [7:0] latch,
                                           logic [7:0] pins);
    data_view = (dir & latch) | (~dir & pins);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] sync_q
);

  logic [NPINS-1:0] meta_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= pin_in[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  // R3: synchronized level trails the first stage by one cycle
  p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q == $past(meta_q));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int AW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               wr,
  input  logic [AW-1:0]      addr,
  input  logic [NPINS-1:0]   wdata,
  input  logic [NPINS-1:0]   sync_in,
  input  logic [NPINS-1:0]   pend_in,
  output logic [NPINS-1:0]   latch_q,
  output logic [NPINS-1:0]   dir_q,
  output logic [NPINS-1:0]   ien_q,
  output logic [2*NPINS-1:0] sens_q,
  output logic [NPINS-1:0]   clr_mask,
  output logic [NPINS-1:0]   rdata
);

  localparam int SW = 2 * NPINS;

  logic do_wr;
  logic wr_data, wr_dir, wr_ien, wr_slo, wr_shi, wr_pend;

  assign do_wr   = sel && wr;
  assign wr_data = do_wr && (addr == AW'(A_DATA));
  assign wr_dir  = do_wr && (addr == AW'(A_DIR));
  assign wr_ien  = do_wr && (addr == AW'(A_IEN));
  assign wr_slo  = do_wr && (addr == AW'(A_SLO));
  assign wr_shi  = do_wr && (addr == AW'(A_SHI));
  assign wr_pend = do_wr && (addr == AW'(A_PEND));

  assign clr_mask = wr_pend ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      sens_q  <= '0;
    end else begin
      if (wr_data) latch_q <= wdata;
      if (wr_dir)  dir_q   <= wdata;
      if (wr_ien)  ien_q   <= wdata;
      if (wr_slo)  sens_q[NPINS-1:0]  <= wdata;
      if (wr_shi)  sens_q[SW-1:NPINS] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (addr)
        AW'(A_DATA): rdata = (dir_q & latch_q) | (~dir_q & sync_in);
        AW'(A_DIR):  rdata = dir_q;
        AW'(A_IEN):  rdata = ien_q;
        AW'(A_SLO):  rdata = sens_q[NPINS-1:0];
        AW'(A_SHI):  rdata = sens_q[SW-1:NPINS];
        AW'(A_PEND): rdata = pend_in;
        default:     rdata = '0;
      endcase
    end
  end

  // R6: a direction write is visible the cycle after
  p_dir_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata));

  // R4: the latch only moves on a data write
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(latch_q));

endmodule

// File: rtl/gpio_evt.sv
module gpio_evt
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   sync_in,
  input  logic [NPINS-1:0]   dir_q,
  input  logic [NPINS-1:0]   ien_q,
  input  logic [2*NPINS-1:0] sens_q,
  input  logic [NPINS-1:0]   clr_mask,
  output logic [NPINS-1:0]   pend_q,
  output logic               irq
);

  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] pin_en;
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] lvl;

  assign pin_en = ~dir_q & ien_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    sens_e s_i;
    assign s_i    = sens_e'(sens_q[2*i +: 2]);
    assign evt[i] = pin_en[i] && edge_hit(s_i, prev_q[i], sync_in[i]);
    assign lvl[i] = pin_en[i] && level_hit(s_i, sync_in[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= sync_in[i];
        if (evt[i])           pend_q[i] <= 1'b1;
        else if (clr_mask[i]) pend_q[i] <= 1'b0;
      end
    end

    // R7: a pending flag only rises on an enabled input pin
    p_pend_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(pin_en[i]));

    // R12: a clear without a competing event empties the flag
    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !evt[i]) |=> !pend_q[i]);

    // R8: a qualified event always leaves the flag set
    p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> pend_q[i]);
  end

  assign irq = (|pend_q) | (|lvl);

endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic             irq
);

  logic [NPINS-1:0]   sync_w;
  logic [NPINS-1:0]   latch_w, dir_w, ien_w, clr_w, pend_w;
  logic [2*NPINS-1:0] sens_w;

  gpio_sync #(.NPINS(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .sync_q (sync_w)
  );

  gpio_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_sel),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .sync_in  (sync_w),
    .pend_in  (pend_w),
    .latch_q  (latch_w),
    .dir_q    (dir_w),
    .ien_q    (ien_w),
    .sens_q   (sens_w),
    .clr_mask (clr_w),
    .rdata    (bus_rdata)
  );

  gpio_evt #(.NPINS(NPINS)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_w),
    .dir_q    (dir_w),
    .ien_q    (ien_w),
    .sens_q   (sens_w),
    .clr_mask (clr_w),
    .pend_q   (pend_w),
    .irq      (irq)
  );

  assign pad_oe  = dir_w;
  assign pad_out = latch_w;

  // R5: a pin turning into an output keeps the preloaded level
  p_preload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~$past(pad_oe) & (pad_out ^ $past(pad_out))) == '0));

endmodule

// File: tb/sim_gpio_port_irq.sv
module sim_gpio_port_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'hFF;
  logic [7:0] pad_oe, pad_out;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_port_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_now(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // sensitivity decoding restated for the bench
  function automatic logic fall_sets(input int m);
    return (m == 0) || (m == 2) || (m == 3);
  endfunction
  function automatic logic rise_sets(input int m);
    return (m == 1) || (m == 3);
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] s;
    logic [7:0] bitp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pad_oe in reset", {8'd0, pad_oe}, 16'd0);
    chk("R1 irq in reset", {15'd0, irq}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      if (a == 0) continue;
      rd_now(3'(a), v);
      chk($sformatf("R1 reg %0d after reset", a), {8'd0, v}, 16'd0);
    end
    chk("R1 pad_out after reset", {8'd0, pad_out}, 16'd0);

    // R6 readback and unused addresses
    wr(3'd1, 8'h5A); wr(3'd2, 8'hC3); wr(3'd3, 8'h96); wr(3'd4, 8'h69);
    @(negedge clk);
    rd_now(3'd1, v); chk("R6 dir readback", {8'd0, v}, 16'h5A);
    rd_now(3'd2, v); chk("R6 enable readback", {8'd0, v}, 16'hC3);
    rd_now(3'd3, v); chk("R6 sens lo readback", {8'd0, v}, 16'h96);
    rd_now(3'd4, v); chk("R6 sens hi readback", {8'd0, v}, 16'h69);
    rd_now(3'd6, v); chk("R6 addr 6 reads 0", {8'd0, v}, 16'h00);
    rd_now(3'd7, v); chk("R6 addr 7 reads 0", {8'd0, v}, 16'h00);
    chk("R2 pad_oe follows dir", {8'd0, pad_oe}, 16'h5A);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);

    // R4 write latch on inputs
    wr(3'd0, 8'hA5);
    chk("R4 pad_out takes latch", {8'd0, pad_out}, 16'hA5);
    chk("R4 pad_oe unchanged", {8'd0, pad_oe}, 16'h00);
    @(negedge clk);
    pin_in = 8'h3C;
    @(posedge clk);
    @(negedge clk);
    rd_now(3'd0, v); chk("R3 one edge shows old pin", {8'd0, v}, 16'hFF);
    @(posedge clk);
    @(negedge clk);
    rd_now(3'd0, v); chk("R3 two edges show new pin", {8'd0, v}, 16'h3C);

    // R5 preload then enable outputs
    wr(3'd1, 8'h0F);
    chk("R5 pad_oe now output", {8'd0, pad_oe}, 16'h0F);
    chk("R5 preloaded level on first output cycle", {8'd0, pad_out}, 16'hA5);
    @(negedge clk);
    rd_now(3'd0, v);
    chk("R3 mixed read", {8'd0, v}, {8'd0, (8'hA5 & 8'h0F) | (8'h3C & 8'hF0)});
    wr(3'd0, 8'h5A);
    chk("R2 pad_out follows latch", {8'd0, pad_out}, 16'h5A);

    // R7 outputs with enables set raise nothing
    wr(3'd2, 8'hFF);
    wr(3'd1, 8'hFF);
    wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
    @(negedge clk); pin_in = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk); pin_in = 8'hFF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd_now(3'd5, v); chk("R7 no pending on outputs", {8'd0, v}, 16'h00);
    chk("R7 no irq on outputs", {15'd0, irq}, 16'd0);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    @(negedge clk); pin_in = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R7 disabled low level no irq", {15'd0, irq}, 16'd0);
    rd_now(3'd5, v); chk("R7 disabled no pending", {8'd0, v}, 16'h00);
    pin_in = 8'hFF;
    repeat (4) @(posedge clk);

    // sweep every pin in every mode (R8..R12)
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        bitp = 8'(1 << p);
        s = 16'(m) << (2 * p);
        wr(3'd2, bitp);
        wr(3'd3, s[7:0]);
        wr(3'd4, s[15:8]);
        wr(3'd5, 8'hFF);
        @(negedge clk);
        rd_now(3'd5, v);
        chk($sformatf("R12 idle pend p%0d m%0d", p, m), {8'd0, v}, 16'd0);
        chk($sformatf("R12 idle irq p%0d m%0d", p, m), {15'd0, irq}, 16'd0);
        pin_in = 8'h00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk($sformatf("R11 level irq p%0d m%0d", p, m), {15'd0, irq}, {15'd0, m == 0});
        @(posedge clk);
        @(negedge clk);
        rd_now(3'd5, v);
        chk($sformatf("R9 fall pend p%0d m%0d", p, m), {8'd0, v},
            {8'd0, fall_sets(m) ? bitp : 8'h00});
        chk($sformatf("R12 fall irq p%0d m%0d", p, m), {15'd0, irq},
            {15'd0, fall_sets(m) || (m == 0)});
        wr(3'd5, 8'hFF);
        @(negedge clk);
        rd_now(3'd5, v);
        chk($sformatf("R12 cleared p%0d m%0d", p, m), {8'd0, v}, 16'd0);
        chk($sformatf("R11 level after clear p%0d m%0d", p, m), {15'd0, irq}, {15'd0, m == 0});
        pin_in = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd_now(3'd5, v);
        chk($sformatf("R8 rise pend p%0d m%0d", p, m), {8'd0, v},
            {8'd0, rise_sets(m) ? bitp : 8'h00});
        chk($sformatf("R10 rise irq p%0d m%0d", p, m), {15'd0, irq}, {15'd0, rise_sets(m)});
        wr(3'd5, 8'hFF);
      end
    end

    // R12 zero bits leave flags, and set wins over clear
    wr(3'd2, 8'h03); wr(3'd3, 8'h0F); wr(3'd4, 8'h00); wr(3'd5, 8'hFF);
    @(negedge clk); pin_in = 8'hFC;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_now(3'd5, v); chk("R10 both pins pending", {8'd0, v}, 16'h03);
    wr(3'd5, 8'h01);
    @(negedge clk);
    rd_now(3'd5, v); chk("R12 only written bit cleared", {8'd0, v}, 16'h02);
    chk("R12 irq from remaining flag", {15'd0, irq}, 16'd1);
    wr(3'd5, 8'hFF);
    @(negedge clk);
    chk("R12 irq drops with flags", {15'd0, irq}, 16'd0);
    pin_in = 8'hFF;
    @(posedge clk);
    @(posedge clk);
    wr(3'd5, 8'h03);
    @(negedge clk);
    rd_now(3'd5, v); chk("R12 event beats clear", {8'd0, v}, 16'h03);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule